// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block turns a functional clock into the I2C serial clock for a master. A programmable prescaler divides the functional clock into a sampling tick. Two 16-bit timing words set how many sampling ticks the clock spends low and how many it spends high. Each word packs two counts. The lower byte is used for standard and fast transfers, and also for the first phase of a high-speed transfer, where the master code is sent at fast rate. The upper byte is used for the second, high-speed phase.

A byte engine raises the high-speed select once the master code has gone out. The generator applies the new counts from the next phase boundary. While the generator is enabled it runs the clock without a break. It reports every timed rising and falling edge with a one-cycle strobe, so the engine can sample and drive the data line. Clearing the enable releases the clock line and clears all counters.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and after reset, until the enable is set, `scl_o` is 1 and `sample_tick_o`, `scl_rise_o` and `scl_fall_o` are 0.
- R2: While enabled with a stable prescale value P, `sample_tick_o` is high for one functional cycle out of every P+1.
- R3: With `hs_phase_i` = 0, every low phase of `scl_o` lasts (bits 7:0 of `scl_low_cfg_i` + PHASE_OFF) sampling ticks, which is that count times (P+1) functional cycles.
- R4: With `hs_phase_i` = 0, every high phase of `scl_o` lasts (bits 7:0 of `scl_high_cfg_i` + PHASE_OFF) sampling ticks.
- R5: With `hs_phase_i` = 1, the low and high phases use bits 15:8 of their words in place of bits 7:0, with the same offset.
- R6: `hs_phase_i` and both timing words are sampled only when a phase begins. A change during a phase takes effect from the next phase.
- R7: One cycle after the enable is seen clear, `scl_o` is 1 and no tick or strobe is produced. The prescaler and the phase counter restart from zero on the next enable.
- R8: The first falling edge after the enable is set comes on the first sampling tick, P+1 cycles after the enable.
- R9: `scl_rise_o` is high for exactly the one cycle in which `scl_o` has just gone from 0 to 1 on a timed transition, and `scl_fall_o` likewise for 1 to 0. The two strobes are never high together.
- R10: The count extremes work: a byte of 0 gives a phase of PHASE_OFF ticks, and a byte of 255 gives 255+PHASE_OFF ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the generator; when clear the counters are held in reset |
| hs_phase_i | input | 1 | 0 selects the lower timing bytes, 1 the upper ones |
| prescale_i | input | PSC_W (8) | Prescaler value P; the tick rate is the clock divided by P+1 |
| scl_low_cfg_i | input | 2*BYTE_W (16) | Low-phase counts: bits 7:0 fast, bits 15:8 high speed |
| scl_high_cfg_i | input | 2*BYTE_W (16) | High-phase counts in the same layout |
| sample_tick_o | output | 1 | Sampling tick for the bit engine |
| scl_o | output | 1 | Serial clock level: 0 drives low, 1 releases |
| scl_rise_o | output | 1 | Strobe on a timed rising edge of scl_o |
| scl_fall_o | output | 1 | Strobe on a timed falling edge of scl_o |

## Verification
The hardest case to reach is a mode switch in the middle of a phase. The bench has to see that the running phase keeps the count it latched at entry, and that only the next phase takes the new byte. The bench waits for a falling strobe and lets a few cycles pass. It then flips `hs_phase_i` and measures the rest of that low phase and the following high phase against counts taken from different bytes. A disable in the middle of a phase is reached the same way, followed by a re-enable that must give the full start-up delay again.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int unsigned NUM_PHASE_CFG = 2;
  localparam int unsigned CFG_LOW_IDX   = 0;
  localparam int unsigned CFG_HIGH_IDX  = 1;
endpackage

// File: rtl/i2c_scl_tick_gen.sv
module i2c_scl_tick_gen #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  // >= keeps the divider from running away if psc_i drops below the count
  assign tick_o = en_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!en_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0 && en_i) |=> (!tick_o || !$stable(psc_i))); // R2

  AST_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (div_q == '0)); // R7
endmodule

// File: rtl/i2c_scl_cfg_sel.sv
module i2c_scl_cfg_sel
  import i2c_scl_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                                  hs_i,
  input  logic [NUM_PHASE_CFG-1:0][2*BYTE_W-1:0] cfg_i,
  output logic [NUM_PHASE_CFG-1:0][BYTE_W-1:0]   cnt_o
);
  for (genvar g = 0; g < NUM_PHASE_CFG; g++) begin : g_sel
    assign cnt_o[g] = hs_i ? cfg_i[g][2*BYTE_W-1:BYTE_W] : cfg_i[g][BYTE_W-1:0];
  end
endmodule

// File: rtl/i2c_scl_phase_ctrl.sv
module i2c_scl_phase_ctrl
  import i2c_scl_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PHASE_OFF = 2,
  localparam int unsigned CW       = $clog2((1 << BYTE_W) + PHASE_OFF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] low_cnt_i,
  input  logic [BYTE_W-1:0] high_cnt_i,
  output logic              scl_o,
  output logic              rise_o,
  output logic              fall_o
);
  scl_phase_e state_q;
  logic [CW-1:0] cnt_q, lim_q;
  logic [CW-1:0] low_lim, high_lim;

  // last tick index of a phase: count + offset - 1
  assign low_lim  = CW'(low_cnt_i)  + CW'(PHASE_OFF - 1);
  assign high_lim = CW'(high_cnt_i) + CW'(PHASE_OFF - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      scl_o   <= 1'b1;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!en_i) begin
        state_q <= PH_IDLE;
        cnt_q   <= '0;
        scl_o   <= 1'b1;
      end else if (tick_i) begin
        unique case (state_q)
          PH_IDLE: begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
            lim_q   <= low_lim;
            scl_o   <= 1'b0;
            fall_o  <= 1'b1;
          end
          PH_LOW: begin
            if (cnt_q == lim_q) begin
              state_q <= PH_HIGH;
              cnt_q   <= '0;
              lim_q   <= high_lim;
              scl_o   <= 1'b1;
              rise_o  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_q == lim_q) begin
              state_q <= PH_LOW;
              cnt_q   <= '0;
              lim_q   <= low_lim;
              scl_o   <= 1'b0;
              fall_o  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            scl_o   <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_IDLE) |-> (cnt_q <= lim_q)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R9

  AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (scl_o && !$past(scl_o))); // R9

  AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!scl_o && $past(scl_o))); // R9

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !rise_o && !fall_o)); // R7

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (scl_o != $past(scl_o))) |-> $past(tick_i)); // R2
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int unsigned PSC_W     = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PHASE_OFF = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                hs_phase_i,
  input  logic [PSC_W-1:0]    prescale_i,
  input  logic [2*BYTE_W-1:0] scl_low_cfg_i,
  input  logic [2*BYTE_W-1:0] scl_high_cfg_i,
  output logic                sample_tick_o,
  output logic                scl_o,
  output logic                scl_rise_o,
  output logic                scl_fall_o
);
  logic                                  tick;
  logic [NUM_PHASE_CFG-1:0][2*BYTE_W-1:0] cfg;
  logic [NUM_PHASE_CFG-1:0][BYTE_W-1:0]   cnt_sel;

  assign cfg[CFG_LOW_IDX]  = scl_low_cfg_i;
  assign cfg[CFG_HIGH_IDX] = scl_high_cfg_i;
  assign sample_tick_o     = tick;

  i2c_scl_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (enable_i),
    .psc_i (prescale_i),
    .tick_o(tick)
  );

  i2c_scl_cfg_sel #(.BYTE_W(BYTE_W)) u_sel (
    .hs_i (hs_phase_i),
    .cfg_i(cfg),
    .cnt_o(cnt_sel)
  );

  i2c_scl_phase_ctrl #(.BYTE_W(BYTE_W), .PHASE_OFF(PHASE_OFF)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .tick_i    (tick),
    .low_cnt_i (cnt_sel[CFG_LOW_IDX]),
    .high_cnt_i(cnt_sel[CFG_HIGH_IDX]),
    .scl_o     (scl_o),
    .rise_o    (scl_rise_o),
    .fall_o    (scl_fall_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !$past(enable_i)) |-> (scl_o && !sample_tick_o)); // R1
endmodule

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OFF        = 2;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        hs = 1'b0;
  logic [7:0]  psc = '0;
  logic [15:0] low_cfg = '0;
  logic [15:0] high_cfg = '0;
  logic        tick, scl, rise, fall;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_timer #(.PSC_W(8), .BYTE_W(8), .PHASE_OFF(OFF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .hs_phase_i(hs),
    .prescale_i(psc), .scl_low_cfg_i(low_cfg), .scl_high_cfg_i(high_cfg),
    .sample_tick_o(tick), .scl_o(scl), .scl_rise_o(rise), .scl_fall_o(fall)
  );

  function automatic int exp_len(input logic [15:0] cfg, input logic sel_hs,
                                 input logic [7:0] p);
    int b;
    b = sel_hs ? int'(cfg[15:8]) : int'(cfg[7:0]);
    return (b + OFF) * (int'(p) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until the selected strobe is sampled high
  task automatic wait_strobe(input bit want_rise, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_rise ? rise : fall) && n < 100000);
  endtask

  task automatic start(input logic [7:0] p, input string req);
    int n;
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    psc = p;
    en = 1'b1;
    wait_strobe(1'b0, n);
    chk(n == int'(p) + 1, req, n, int'(p) + 1);
  endtask

  task automatic measure(input int e_low, input int e_high, input string rl,
                         input string rh);
    int n;
    wait_strobe(1'b1, n);
    chk(n == e_low, rl, n, e_low);
    wait_strobe(1'b0, n);
    chk(n == e_high, rh, n, e_high);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, t0;
    void'($urandom(32'h5C1A));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(scl == 1'b1 && !rise && !fall && !tick, "R1 in reset", int'(scl), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1 && !rise && !fall && !tick, "R1 after reset", int'(scl), 1);

    // R2: tick period with P=3
    low_cfg = 16'h0404; high_cfg = 16'h0404; hs = 1'b0;
    start(8'd3, "R8 p3");
    t0 = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) begin
        if (t0 >= 0) chk(i - t0 == 4, "R2 tick period", i - t0, 4);
        t0 = i;
      end
      if (rise && fall) chk(1'b0, "R9 strobes together", 1, 0);
    end

    // R3/R4 fast mode directed
    low_cfg = 16'h3307; high_cfg = 16'h2205; hs = 1'b0;
    start(8'd1, "R8 p1");
    measure(exp_len(low_cfg, 0, 1), exp_len(high_cfg, 0, 1), "R3 fast low", "R4 fast high");
    measure(exp_len(low_cfg, 0, 1), exp_len(high_cfg, 0, 1), "R3 fast low 2", "R4 fast high 2");

    // R5 high-speed bytes
    hs = 1'b1;
    start(8'd0, "R8 p0");
    measure(exp_len(low_cfg, 1, 0), exp_len(high_cfg, 1, 0), "R5 hs low", "R5 hs high");

    // R10 extremes
    low_cfg = 16'h0000; high_cfg = 16'h00FF; hs = 1'b0;
    start(8'd0, "R8 p0 min");
    measure(OFF, 255 + OFF, "R10 byte 0", "R10 byte 255");
    hs = 1'b0;

    // R6 mode switch mid low phase
    low_cfg = 16'h0210; high_cfg = 16'h030C; hs = 1'b0;
    start(8'd1, "R8 switch");
    repeat (5) @(negedge clk);
    hs = 1'b1;
    wait_strobe(1'b1, n);
    chk(n + 5 == exp_len(low_cfg, 0, 1), "R6 low keeps old count", n + 5, exp_len(low_cfg, 0, 1));
    wait_strobe(1'b0, n);
    chk(n == exp_len(high_cfg, 1, 1), "R6 high takes new count", n, exp_len(high_cfg, 1, 1));

    // R7 disable mid phase, then restart
    hs = 1'b0;
    low_cfg = 16'h0009; high_cfg = 16'h0009;
    start(8'd2, "R8 p2");
    repeat (4) @(negedge clk);
    en = 1'b0;
    #1;
    chk(!tick, "R7 tick gated", int'(tick), 0);
    @(negedge clk);
    chk(scl == 1'b1 && !rise && !fall, "R7 release", int'(scl), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(scl == 1'b1 && !rise && !fall && !tick, "R7 quiet while off", int'(scl), 1);
    end
    start(8'd2, "R7 restart latency");
    measure(exp_len(low_cfg, 0, 2), exp_len(high_cfg, 0, 2), "R7 low after restart", "R4 high after restart");

    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [7:0] p;
      p = 8'($urandom % 4);
      low_cfg  = {8'($urandom % 20), 8'($urandom % 24)};
      high_cfg = {8'($urandom % 20), 8'($urandom % 24)};
      hs = 1'($urandom % 2);
      start(p, "R8 random");
      measure(exp_len(low_cfg, hs, p), exp_len(high_cfg, hs, p),
              hs ? "R5 random low" : "R3 random low",
              hs ? "R5 random high" : "R4 random high");
    end

    en = 1'b0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule